// File: doc/BRIEF.md
# Unaligned Byte-to-Word Program Merger

This block turns a byte-addressed write request into a series of aligned word-program commands for a non-volatile memory. A request gives a start byte address and a byte count, and the source bytes then arrive on a valid/ready stream. The block works one target word at a time. It reads the current contents of the word and overlays the new bytes on their byte lanes. Lanes outside the request keep the bytes that were read back. It then checks that the merged value needs no bit to go from 0 to 1, and hands the word to a program controller through a request/acknowledge handshake.

A partial word at the head or tail of an unaligned request is completed from memory. The words in between are packed little-endian. The sequence stops at the first problem: a word that is not erased enough, or a failed program command. Exactly one done pulse with a status code closes every request. Status codes are 0 = ok, 1 = not erased, 2 = timeout, 3 = protected. The program controller reports its result on the same 2-bit encoding.

Top module: `byte_word_merger`

## Requirements
- R1: The first read and program address is the start address with its two low bits cleared. After each successful word program, the next word address is 4 higher. Every read and program address has bits 1:0 equal to 0.
- R2: For an unaligned start with offset k = address bits 1:0, lanes 0..k-1 of the first word keep the bytes read from memory. The first source byte goes to lane k, and the following source bytes go to the lanes above it.
- R3: If a request ends inside its first word, the lanes above its last byte keep the bytes read from memory.
- R4: A whole word between head and tail is packed little-endian: the first of its four source bytes goes to bits 7:0 and the fourth to bits 31:24.
- R5: Leftover tail bytes fill the lowest lanes of the last word. Its upper lanes keep the bytes read from memory.
- R6: If (merged AND current) differs from merged, no program command is issued for that word. The request ends with done and status 1.
- R7: If a program acknowledge carries a non-zero status, the next cycle gives done with that same status. No further read or program command is issued.
- R8: A request with byte count 0 is followed one cycle later by done with status 0. It issues no read and no program command.
- R9: Each accepted request produces exactly one done pulse. busy is 0 out of reset, and is 1 from acceptance until done.
- R10: A read or program request, once raised, stays high with a stable address and data until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when busy is 0 |
| start_addr | input | AW | Start byte address |
| byte_count | input | LW | Number of bytes to write |
| busy | output | 1 | A request is in progress |
| src_valid | input | 1 | Source byte valid |
| src_byte | input | 8 | Source byte |
| src_ready | output | 1 | Block accepts a source byte |
| rd_req | output | 1 | Read of the current memory word |
| rd_addr | output | AW | Word address to read |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 8*LANES | Current memory word |
| pg_req | output | 1 | Word-program command |
| pg_addr | output | AW | Word address to program |
| pg_data | output | 8*LANES | Merged word to program |
| pg_ack | input | 1 | Program command finished |
| pg_status | input | 2 | Program result (0 ok, 2 timeout, 3 protected) |
| done | output | 1 | One-cycle end-of-request pulse |
| done_status | output | 2 | Result code, valid with done |

## Verification
The hardest cases to reach are an error that arrives partway through a sequence, after some words have already been programmed. Examples are a not-erased word right after a good one, or a protected status on the second of three commands. The stimulus seeds the responder memory with partly cleared words at chosen addresses, and it programs the memory responder to return an error on a chosen command index. The source stream runs with periodic gaps, so that lane filling is also exercised with stalls between bytes.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_NOT_ERASED = 2'd1,
    ST_TIMEOUT    = 2'd2,
    ST_PROTECTED  = 2'd3
  } bwm_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_FILL,
    PH_CHECK,
    PH_PROG
  } bwm_phase_e;
endpackage

// File: rtl/bwm_reset_sync.sv
module bwm_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bwm_lane_buf.sv
module bwm_lane_buf #(
  parameter int LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_en,
  input  logic [8*LANES-1:0]        load_word,
  input  logic                      put_en,
  input  logic [$clog2(LANES)-1:0]  put_lane,
  input  logic [7:0]                put_byte,
  output logic [8*LANES-1:0]        old_word,
  output logic [8*LANES-1:0]        new_word
);
  localparam int DW = 8 * LANES;
  localparam int OW = $clog2(LANES);

  logic [DW-1:0] old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       old_q <= '0;
    else if (load_en) old_q <= load_word;
  end

  assign old_word = old_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                lane_q <= '0;
      else if (load_en)                          lane_q <= load_word[8*g +: 8];
      else if (put_en && (put_lane == OW'(g)))   lane_q <= put_byte;
    end
    assign new_word[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/bwm_erase_check.sv
module bwm_erase_check #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] new_word,
  input  logic [DW-1:0] old_word,
  output logic          writable
);
  assign writable = ((new_word & old_word) == new_word);
endmodule

// File: rtl/byte_word_merger.sv
module byte_word_merger
  import bwm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        start_addr,
  input  logic [LW-1:0]        byte_count,
  output logic                 busy,
  input  logic                 src_valid,
  input  logic [7:0]           src_byte,
  output logic                 src_ready,
  output logic                 rd_req,
  output logic [AW-1:0]        rd_addr,
  input  logic                 rd_ack,
  input  logic [8*LANES-1:0]   rd_data,
  output logic                 pg_req,
  output logic [AW-1:0]        pg_addr,
  output logic [8*LANES-1:0]   pg_data,
  input  logic                 pg_ack,
  input  logic [1:0]           pg_status,
  output logic                 done,
  output logic [1:0]           done_status
);
  localparam int DW = 8 * LANES;
  localparam int OW = $clog2(LANES);

  logic rst_sync_n;

  bwm_phase_e     phase_q, phase_d;
  logic [AW-1:0]  waddr_q, waddr_d;
  logic [OW-1:0]  lane_q, lane_d;
  logic [LW-1:0]  left_q, left_d;
  logic           done_q, done_d;
  logic [1:0]     dstat_q, dstat_d;

  logic           load_en, put_en, writable, last_byte;
  logic [DW-1:0]  old_word, new_word;

  bwm_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign load_en = (phase_q == PH_READ) && rd_ack;
  assign put_en  = (phase_q == PH_FILL) && src_valid;

  bwm_lane_buf #(.LANES(LANES)) u_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_en   (load_en),
    .load_word (rd_data),
    .put_en    (put_en),
    .put_lane  (lane_q),
    .put_byte  (src_byte),
    .old_word  (old_word),
    .new_word  (new_word)
  );

  bwm_erase_check #(.DW(DW)) u_chk (
    .new_word (new_word),
    .old_word (old_word),
    .writable (writable)
  );

  assign last_byte = (lane_q == OW'(LANES - 1)) || (left_q == LW'(1));

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    waddr_d = waddr_q;
    lane_d  = lane_q;
    left_d  = left_q;
    done_d  = 1'b0;
    dstat_d = dstat_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          if (byte_count == '0) begin
            done_d  = 1'b1;
            dstat_d = ST_OK;
          end else begin
            phase_d = PH_READ;
            waddr_d = {start_addr[AW-1:OW], {OW{1'b0}}};
            lane_d  = start_addr[OW-1:0];
            left_d  = byte_count;
          end
        end
      end
      PH_READ: begin
        if (rd_ack) phase_d = PH_FILL;
      end
      PH_FILL: begin
        if (src_valid) begin
          left_d = left_q - LW'(1);
          lane_d = lane_q + OW'(1);
          if (last_byte) phase_d = PH_CHECK;
        end
      end
      PH_CHECK: begin
        if (!writable) begin
          done_d  = 1'b1;
          dstat_d = ST_NOT_ERASED;
          phase_d = PH_IDLE;
        end else begin
          phase_d = PH_PROG;
        end
      end
      PH_PROG: begin
        if (pg_ack) begin
          if (pg_status != 2'(ST_OK)) begin
            done_d  = 1'b1;
            dstat_d = pg_status;
            phase_d = PH_IDLE;
          end else if (left_q == '0) begin
            done_d  = 1'b1;
            dstat_d = ST_OK;
            phase_d = PH_IDLE;
          end else begin
            waddr_d = waddr_q + AW'(LANES);
            lane_d  = '0;
            phase_d = PH_READ;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_IDLE;
      waddr_q <= '0;
      lane_q  <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
      dstat_q <= '0;
    end else begin
      phase_q <= phase_d;
      waddr_q <= waddr_d;
      lane_q  <= lane_d;
      left_q  <= left_d;
      done_q  <= done_d;
      dstat_q <= dstat_d;
    end
  end

  assign busy        = (phase_q != PH_IDLE);
  assign src_ready   = (phase_q == PH_FILL);
  assign rd_req      = (phase_q == PH_READ);
  assign rd_addr     = waddr_q;
  assign pg_req      = (phase_q == PH_PROG);
  assign pg_addr     = waddr_q;
  assign pg_data     = new_word;
  assign done        = done_q;
  assign done_status = dstat_q;
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [LW-1:0]       byte_count,
  input logic                busy,
  input logic                rd_req,
  input logic [AW-1:0]       rd_addr,
  input logic                rd_ack,
  input logic [8*LANES-1:0]  rd_data,
  input logic                pg_req,
  input logic [AW-1:0]       pg_addr,
  input logic [8*LANES-1:0]  pg_data,
  input logic                pg_ack,
  input logic [1:0]          pg_status,
  input logic                done,
  input logic [1:0]          done_status
);
  localparam int DW = 8 * LANES;
  localparam int OW = $clog2(LANES);

  logic [DW-1:0] seen_old_q;
  logic          open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_old_q <= '0;
      open_q     <= 1'b0;
    end else begin
      if (rd_req && rd_ack) seen_old_q <= rd_data;
      if (start && !busy)   open_q     <= 1'b1;
      else if (done)        open_q     <= 1'b0;
    end
  end

  assert_aligned_pg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req |-> (pg_addr[OW-1:0] == '0));
  assert_aligned_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[OW-1:0] == '0));
  assert_only_erasable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req |-> ((pg_data & seen_old_q) == pg_data));
  assert_error_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req && pg_ack && (pg_status != 2'd0)) |=>
      (done && (done_status == $past(pg_status)) && !pg_req && !rd_req));
  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (byte_count == '0)) |=> (done && (done_status == 2'd0) && !rd_req && !pg_req));
  assert_done_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> open_q);
  assert_pg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req && !pg_ack) |=> (pg_req && $stable(pg_addr) && $stable(pg_data)));
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
endmodule

bind byte_word_merger bwm_checker #(.AW(AW), .LW(LW), .LANES(LANES)) u_bwm_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start       (start),
  .byte_count  (byte_count),
  .busy        (busy),
  .rd_req      (rd_req),
  .rd_addr     (rd_addr),
  .rd_ack      (rd_ack),
  .rd_data     (rd_data),
  .pg_req      (pg_req),
  .pg_addr     (pg_addr),
  .pg_data     (pg_data),
  .pg_ack      (pg_ack),
  .pg_status   (pg_status),
  .done        (done),
  .done_status (done_status)
);

// File: tb/test_byte_word_merger.sv
module test_byte_word_merger;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] start_addr;
  logic [15:0] byte_count;
  logic        busy;
  logic        src_valid;
  logic [7:0]  src_byte;
  logic        src_ready;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic        pg_req;
  logic [31:0] pg_addr;
  logic [31:0] pg_data;
  logic        pg_ack;
  logic [1:0]  pg_status;
  logic        done;
  logic [1:0]  done_status;

  always #4 clk = ~clk;  // 125 MHz

  byte_word_merger i_byte_word_merger (.*);

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [31:0] mem [64];
  logic [7:0]  src_q [$];
  logic [7:0]  stim [$];
  logic [31:0] exp_addr_q [$];
  logic [31:0] exp_data_q [$];
  int          err_idx;
  logic [1:0]  err_code;
  int          pg_count;
  int          gap_ctr;
  int          pg_wait;
  string       cur_tag;

  logic        src_hs, pg_hs;
  logic [31:0] pg_addr_s, pg_data_s;
  logic [1:0]  pg_stat_s;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // handshake capture at the edge (pre-update values)
  always @(posedge clk) begin
    cycles    <= cycles + 1;
    src_hs    <= src_valid && src_ready;
    pg_hs     <= pg_req && pg_ack;
    pg_addr_s <= pg_addr;
    pg_data_s <= pg_data;
    pg_stat_s <= pg_status;
  end

  // responders and per-clock comparison against the expected command list
  always @(negedge clk) begin
    if (rst_n) begin
      if (src_hs && (src_q.size() > 0)) void'(src_q.pop_front());
      if (pg_hs) begin
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected program command", pg_addr_s, 32'h0);
        end else begin
          chk(pg_addr_s == exp_addr_q[0], "R1", {cur_tag, " program address"}, pg_addr_s, exp_addr_q[0]);
          chk(pg_data_s == exp_data_q[0], cur_tag, "program data", pg_data_s, exp_data_q[0]);
          void'(exp_addr_q.pop_front());
          void'(exp_data_q.pop_front());
        end
        if (pg_stat_s == 2'd0) mem[pg_addr_s[7:2]] = pg_data_s;
        pg_count++;
      end
      gap_ctr++;
      src_valid = (src_q.size() > 0) && ((gap_ctr % 4) != 3);
      src_byte  = (src_q.size() > 0) ? src_q[0] : 8'h00;
      rd_ack    = rd_req && !rd_ack;
      rd_data   = mem[rd_addr[7:2]];
      if (pg_ack) begin
        pg_ack  = 1'b0;
        pg_wait = 0;
      end else if (pg_req) begin
        pg_wait++;
        if (pg_wait >= 2) begin
          pg_ack    = 1'b1;
          pg_status = (pg_count == err_idx) ? err_code : 2'd0;
        end
      end
    end
  end

  task automatic run(input string tag, input logic [31:0] addr, input int len,
                     input int eidx, input logic [1:0] ecode);
    logic [31:0] sh [64];
    logic [31:0] w, old;
    logic [1:0]  want;
    int k, lane, cmd, seen;
    logic [1:0] got;
    logic [31:0] wa;
    for (int i = 0; i < 64; i++) sh[i] = mem[i];
    k = 0; cmd = 0; want = 2'd0;
    wa = {addr[31:2], 2'b00};
    lane = int'(addr[1:0]);
    while (k < len) begin
      old = sh[wa[7:2]];
      w = old;
      while ((lane < 4) && (k < len)) begin
        w[8*lane +: 8] = stim[k];
        k++; lane++;
      end
      if ((w & old) != w) begin want = 2'd1; break; end
      exp_addr_q.push_back(wa);
      exp_data_q.push_back(w);
      if (cmd == eidx) begin want = ecode; break; end
      sh[wa[7:2]] = w;
      cmd++; wa += 4; lane = 0;
    end
    cur_tag  = tag;
    err_idx  = eidx;
    err_code = ecode;
    pg_count = 0;
    for (int i = 0; i < len; i++) src_q.push_back(stim[i]);
    @(negedge clk);
    start = 1'b1; start_addr = addr; byte_count = 16'(len);
    @(negedge clk);
    start = 1'b0;
    seen = 0; got = 2'd0;
    if (done) begin seen++; got = done_status; end
    for (int t = 0; t < 3000 && seen == 0; t++) begin
      @(negedge clk);
      if (done) begin seen++; got = done_status; end
    end
    repeat (3) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk(seen == 1, "R9", {tag, " done pulse count"}, 32'(seen), 32'd1);
    chk(got == want, tag, "done status", 32'(got), 32'(want));
    chk(exp_addr_q.size() == 0, tag, "missing program commands", 32'(exp_addr_q.size()), 32'd0);
    chk(!busy, "R9", {tag, " busy after done"}, 32'(busy), 32'd0);
    exp_addr_q.delete();
    exp_data_q.delete();
    src_q.delete();
    stim.delete();
    err_idx = -1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hFFFF_FFFF;
    rst_n = 1'b0; start = 1'b0; start_addr = '0; byte_count = '0;
    src_valid = 1'b0; src_byte = '0; rd_ack = 1'b0; rd_data = '0;
    pg_ack = 1'b0; pg_status = '0; err_idx = -1; err_code = '0;
    pg_count = 0; gap_ctr = 0; pg_wait = 0; cur_tag = "";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(!busy && !done && !pg_req && !rd_req && !src_ready, "R9", "reset state outputs",
        {27'd0, busy, done, pg_req, rd_req, src_ready}, 32'd0);

    // R8: empty request
    run("R8", 32'h0000_0010, 0, -1, 2'd0);

    // R4: aligned, two whole words, little-endian
    stim = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
    run("R4", 32'h0000_0010, 8, -1, 2'd0);

    // R3: short request inside the head word, memory lanes preserved
    mem[32'h40 >> 2] = 32'h1234_5678;
    stim = '{8'h00, 8'h00};
    run("R3", 32'h0000_0041, 2, -1, 2'd0);

    // R2/R4/R5: unaligned head, a whole word, tail
    mem[32'h28 >> 2] = 32'hA5C3_FFFF;
    stim = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09};
    run("R2", 32'h0000_0021, 9, -1, 2'd0);

    // R5: aligned start with tail bytes below memory lanes
    mem[32'h34 >> 2] = 32'h5A3C_FFFF;
    stim = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'h01, 8'h02};
    run("R5", 32'h0000_0030, 6, -1, 2'd0);

    // R6: first word not erased
    mem[32'h50 >> 2] = 32'h0000_FFFF;
    stim = '{8'h11, 8'h22, 8'h33, 8'h44};
    run("R6", 32'h0000_0050, 4, -1, 2'd0);

    // R6: second word not erased after a good first word
    mem[32'h64 >> 2] = 32'h0000_0000;
    stim = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h01, 8'h00, 8'h00, 8'h00};
    run("R6", 32'h0000_0060, 8, -1, 2'd0);

    // R7: protected on the second of three commands
    stim = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hC9, 8'hCA, 8'hCB};
    run("R7", 32'h0000_0080, 12, 1, 2'd3);

    // R7: timeout on the first command of an unaligned request
    stim = '{8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hD5};
    run("R7", 32'h0000_00A2, 5, 0, 2'd2);

    // R1: longer run across several words
    stim.delete();
    for (int i = 0; i < 17; i++) stim.push_back(8'(8'h30 + i));
    run("R1", 32'h0000_00C3, 17, -1, 2'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    wait (cycles >= 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule